// File: doc/BRIEF.md
# Shared Linked-List Multi-Queue Cell Buffer

This block holds up to 160 cell descriptors in one storage pool that up to 31 per-port FIFO queues share. Each queue is a linked list threaded through a next-pointer array. Unused slots sit on a separate free list. A write names a port and appends one descriptor word to that port's queue. A read names a port and returns the oldest descriptor of that queue one cycle later, or a not-valid indication when the queue is empty.

Every queue has its own programmable upper fill threshold. Reaching it raises a back-pressure bit for that queue alone. An upstream sender uses these bits to stop sending to busy ports without stalling the others. The queues may be over-subscribed: the thresholds need not add up to the pool size. A separate global threshold on total occupancy raises a halt, so the pool as a whole never has to drop a cell. A write that still arrives while the pool is full is discarded and recorded in a sticky overflow flag.

Top module: `linked_cell_buffer`

## Requirements
- R1: After reset, no cells are stored. All back-pressure bits, `halt` and `overflow` are 0, and a read of any queue returns `rd_valid`=0. The reset queue threshold is 16 and the reset global threshold is 144.
- R2: The queue is selected by address bits [7:3]. Bits [2:0] are a sub-port field and have no effect. Queue number 31 is unused: writes to it are discarded without using storage, and reads from it return `rd_valid`=0.
- R3: Each queue returns its cells in write order. A read issued with `rd_en` in one cycle presents `rd_valid`=1 and the data in the following cycle.
- R4: A read of an empty queue gives `rd_valid`=0 in the following cycle and changes no state.
- R5: `bp[q]` is 1 exactly while queue q holds at least its threshold of cells. It updates in the cycle after the write or read that changes the count, with no hysteresis.
- R6: Back-pressure is advisory and confined to its own queue. Writes and reads on other queues, and further writes to the back-pressured queue, still take effect.
- R7: A config write with `cfg_sel` 0..30 sets that queue's threshold. `cfg_sel`=31 sets the global threshold. Thresholds are independent, and their sum may exceed 160.
- R8: `halt` is 1 exactly while the total number of stored cells is at least the global threshold, and it drops as soon as the total falls below it.
- R9: The pool holds 160 cells. A write to a valid queue while all 160 slots are in use at the start of that cycle is discarded and sets `overflow`, which stays at 1 until reset. This applies even when a read in the same cycle frees a slot.
- R10: A write and a read on the same empty queue in the same cycle give `rd_valid`=0. The written cell is kept and is returned by the next read.
- R11: A write and a read in the same cycle on different queues both take effect. A slot freed by a read can be allocated again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write a descriptor this cycle |
| wr_addr | input | 8 | Port [7:3] and ignored sub-port [2:0] for the write |
| wr_data | input | 16 | Descriptor word to store |
| rd_en | input | 1 | Read the oldest descriptor of a queue |
| rd_addr | input | 8 | Port [7:3] and ignored sub-port [2:0] for the read |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 16 | Descriptor returned by the read |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_sel | input | 5 | Queue 0..30, or 31 for the global threshold |
| cfg_val | input | 8 | Threshold value |
| bp | output | 31 | Per-queue back-pressure, bit q for queue q |
| halt | output | 1 | Total occupancy at or above the global threshold |
| overflow | output | 1 | Sticky: a write was discarded because the pool was full |

## Verification
The bench fills the pool completely, then attempts one more write both alone and together with a read that frees a slot. A design that allocated from a stale or empty free list would corrupt a queue's link chain, and the following drain would return cells out of order or lose them. The bench also writes and reads the same empty queue in one cycle, which catches a design that bypasses the new cell straight to the output. It also reads and writes a queue holding one cell in the same cycle, where a wrong head or tail update breaks the list. The threshold tests step counts across the exact boundary in both directions. They catch off-by-one comparisons, latched back-pressure, and back-pressure that wrongly blocks a neighbouring queue or stops writes.

// File: rtl/linked_cell_buffer.sv
module linked_cell_buffer #(
  parameter int SLOTS    = 160,
  parameter int QUEUES   = 31,
  parameter int QW       = 5,
  parameter int SUBW     = 3,
  parameter int DW       = 16,
  parameter int DEF_QTHR = 16,
  parameter int DEF_GTHR = 144
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [QW+SUBW-1:0]   wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic                 rd_en,
  input  logic [QW+SUBW-1:0]   rd_addr,
  output logic                 rd_valid,
  output logic [DW-1:0]        rd_data,
  input  logic                 cfg_we,
  input  logic [QW-1:0]        cfg_sel,
  input  logic [$clog2(SLOTS+1)-1:0] cfg_val,
  output logic [QUEUES-1:0]    bp,
  output logic                 halt,
  output logic                 overflow
);
  localparam int ADDRW = QW + SUBW;
  localparam int PW    = $clog2(SLOTS);
  localparam int CW    = $clog2(SLOTS+1);
  localparam logic [QW:0] QLIM = (QW+1)'(QUEUES);

  logic [PW-1:0] nxt [SLOTS];
  logic [DW-1:0] mem [SLOTS];
  logic [PW-1:0] qhead [QUEUES];
  logic [PW-1:0] qtail [QUEUES];
  logic [CW-1:0] qcnt  [QUEUES];
  logic [CW-1:0] qthr  [QUEUES];
  logic [PW-1:0] free_head, free_tail;
  logic [CW-1:0] free_cnt, total, gthr;

  logic [QW-1:0] wq, rq, wq_i, rq_i;
  logic          wq_ok, rq_ok, do_wr, do_rd, drop, same;
  logic [PW-1:0] wslot, rslot;
  logic [CW-1:0] wq_cnt, rq_cnt;

  assign wq     = wr_addr[ADDRW-1:SUBW];
  assign rq     = rd_addr[ADDRW-1:SUBW];
  assign wq_ok  = {1'b0, wq} < QLIM;
  assign rq_ok  = {1'b0, rq} < QLIM;
  assign wq_i   = wq_ok ? wq : '0;
  assign rq_i   = rq_ok ? rq : '0;
  assign wq_cnt = qcnt[wq_i];
  assign rq_cnt = qcnt[rq_i];
  assign wslot  = free_head;
  assign rslot  = qhead[rq_i];
  assign do_wr  = wr_en && wq_ok && (free_cnt != '0);
  assign drop   = wr_en && wq_ok && (free_cnt == '0);
  assign do_rd  = rd_en && rq_ok && (rq_cnt != '0);
  assign same   = do_wr && do_rd && (wq_i == rq_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) nxt[i] <= PW'((i + 1) % SLOTS);
      for (int q = 0; q < QUEUES; q++) begin
        qhead[q] <= '0;
        qtail[q] <= '0;
        qcnt[q]  <= '0;
        qthr[q]  <= CW'(DEF_QTHR);
      end
      free_head <= '0;
      free_tail <= PW'(SLOTS - 1);
      free_cnt  <= CW'(SLOTS);
      total     <= '0;
      gthr      <= CW'(DEF_GTHR);
      overflow  <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_valid <= do_rd;
      if (do_rd) rd_data <= mem[rslot];
      if (do_wr) mem[wslot] <= wr_data;
      if (drop) overflow <= 1'b1;

      if (cfg_we) begin
        if ({1'b0, cfg_sel} < QLIM) qthr[cfg_sel] <= cfg_val;
        else gthr <= cfg_val;
      end

      // free list: pop at head for a write, push at tail for a read
      if (do_rd) begin
        free_tail <= rslot;
        if (free_cnt != '0) nxt[free_tail] <= rslot;
        if (free_cnt == '0 || (do_wr && free_cnt == CW'(1))) free_head <= rslot;
        else if (do_wr) free_head <= nxt[free_head];
      end else if (do_wr) begin
        free_head <= nxt[free_head];
      end
      if (do_wr && !do_rd) free_cnt <= free_cnt - CW'(1);
      else if (do_rd && !do_wr) free_cnt <= free_cnt + CW'(1);
      if (do_wr && !do_rd) total <= total + CW'(1);
      else if (do_rd && !do_wr) total <= total - CW'(1);

      // queue lists
      if (do_wr) begin
        if (wq_cnt == '0 || (same && wq_cnt == CW'(1))) qhead[wq_i] <= wslot;
        else nxt[qtail[wq_i]] <= wslot;
        qtail[wq_i] <= wslot;
      end
      if (do_rd && !(same && rq_cnt == CW'(1))) qhead[rq_i] <= nxt[rslot];

      if (!same) begin
        if (do_wr) qcnt[wq_i] <= wq_cnt + CW'(1);
        if (do_rd) qcnt[rq_i] <= rq_cnt - CW'(1);
      end
    end
  end

  for (genvar g = 0; g < QUEUES; g++) begin : g_bp
    assign bp[g] = qcnt[g] >= qthr[g];
  end

  assign halt = total >= gthr;

endmodule

// File: rtl/linked_cell_buffer_chk.sv
module linked_cell_buffer_chk #(
  parameter int SLOTS = 160,
  parameter int ADDRW = 8,
  parameter int SUBW  = 3,
  parameter int CW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [ADDRW-1:0] wr_addr,
  input logic             rd_en,
  input logic [ADDRW-1:0] rd_addr,
  input logic             rd_valid,
  input logic             overflow,
  input logic [CW-1:0]    free_cnt,
  input logic [CW-1:0]    total,
  input logic [CW-1:0]    rq_cnt
);
  AST_POOL_SUM: assert property (@(posedge clk) disable iff (!rst_n) (free_cnt + total) == CW'(SLOTS)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(overflow) |-> $past(wr_en && free_cnt == '0)); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overflow |=> overflow); // R9
  AST_VALID_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> $past(rd_en)); // R3
  AST_EMPTY_RD: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && rq_cnt == '0) |=> !rd_valid); // R4
  AST_Q31_RD: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && rd_addr[ADDRW-1:SUBW] == '1) |=> !rd_valid); // R2
  AST_NO_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en && rd_addr[ADDRW-1:SUBW] == wr_addr[ADDRW-1:SUBW] && rq_cnt == '0) |=> !rd_valid); // R10
endmodule

bind linked_cell_buffer linked_cell_buffer_chk #(
  .SLOTS(SLOTS), .ADDRW(ADDRW), .SUBW(SUBW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .overflow(overflow),
  .free_cnt(free_cnt), .total(total), .rq_cnt(rq_cnt)
);

// File: tb/sim_linked_cell_buffer.sv
module sim_linked_cell_buffer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, cfg_we = 1'b0;
  logic [7:0]  wr_addr = '0, rd_addr = '0, cfg_val = '0;
  logic [15:0] wr_data = '0;
  logic [4:0]  cfg_sel = '0;
  logic        rd_valid, halt, overflow;
  logic [15:0] rd_data;
  logic [30:0] bp;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  linked_cell_buffer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_val(cfg_val),
    .bp(bp), .halt(halt), .overflow(overflow)
  );

  function automatic logic [7:0] A(input int q, input int sub);
    return {q[4:0], sub[2:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit we, input logic [7:0] wa, input logic [15:0] wd,
                      input bit re, input logic [7:0] ra);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] wa, input logic [15:0] wd);
    step(1'b1, wa, wd, 1'b0, 8'h0);
  endtask

  task automatic rd_exp(input logic [7:0] ra, input bit ev, input logic [15:0] ed, input string req);
    step(1'b0, 8'h0, 16'h0, 1'b1, ra);
    chk(rd_valid == ev, req, rd_valid, ev);
    if (ev) chk(rd_data == ed, req, rd_data, ed);
  endtask

  task automatic cfg(input int sel, input int val);
    cfg_we = 1'b1; cfg_sel = sel[4:0]; cfg_val = val[7:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset;
    chk(bp == '0, "R1 bp", bp, 0);
    chk(!halt, "R1 halt", halt, 0);
    chk(!overflow, "R1 overflow", overflow, 0);
    rd_exp(A(0, 0), 1'b0, 16'h0, "R1 read");
  endtask

  task automatic t_fifo;
    wr(A(3, 0), 16'hA001);
    wr(A(3, 5), 16'hA002);
    wr(A(3, 7), 16'hA003);
    rd_exp(A(3, 2), 1'b1, 16'hA001, "R3 order 1 / R2 sub");
    rd_exp(A(3, 6), 1'b1, 16'hA002, "R3 order 2");
    rd_exp(A(3, 0), 1'b1, 16'hA003, "R3 order 3");
    rd_exp(A(3, 0), 1'b0, 16'h0, "R4 empty");
    rd_exp(A(3, 0), 1'b0, 16'h0, "R4 empty again");
  endtask

  task automatic t_bad_queue;
    cfg(31, 1);
    wr(A(31, 0), 16'hDEAD);
    chk(!halt, "R2 q31 write stores nothing", halt, 0);
    rd_exp(A(31, 0), 1'b0, 16'h0, "R2 q31 read");
    cfg(31, 144);
  endtask

  task automatic t_bp;
    cfg(5, 3);
    wr(A(5, 0), 16'h5001);
    wr(A(5, 0), 16'h5002);
    chk(bp[5] == 1'b0, "R5 below thr", bp[5], 0);
    wr(A(5, 0), 16'h5003);
    chk(bp[5] == 1'b1, "R5 at thr", bp[5], 1);
    chk((bp & ~(31'd1 << 5)) == '0, "R6 other bp clear", bp, 31'd1 << 5);
    wr(A(6, 0), 16'h6001);
    wr(A(5, 0), 16'h5004);
    rd_exp(A(6, 0), 1'b1, 16'h6001, "R6 neighbour");
    rd_exp(A(5, 0), 1'b1, 16'h5001, "R6 bp queue read");
    chk(bp[5] == 1'b1, "R5 still at thr", bp[5], 1);
    rd_exp(A(5, 0), 1'b1, 16'h5002, "R5 read");
    chk(bp[5] == 1'b0, "R5 release", bp[5], 0);
    rd_exp(A(5, 0), 1'b1, 16'h5003, "R6 read");
    rd_exp(A(5, 0), 1'b1, 16'h5004, "R6 write under bp kept");
    cfg(5, 16);
  endtask

  task automatic t_same;
    step(1'b1, A(7, 0), 16'h7001, 1'b1, A(7, 1));
    chk(rd_valid == 1'b0, "R10 no bypass", rd_valid, 0);
    rd_exp(A(7, 0), 1'b1, 16'h7001, "R10 kept");
    wr(A(7, 0), 16'h7002);
    step(1'b1, A(7, 0), 16'h7003, 1'b1, A(7, 0));
    chk(rd_valid && rd_data == 16'h7002, "R11 same queue one cell", rd_data, 16'h7002);
    rd_exp(A(7, 0), 1'b1, 16'h7003, "R11 same queue follow");
    rd_exp(A(7, 0), 1'b0, 16'h0, "R4 drained");
  endtask

  task automatic t_rw_diff;
    wr(A(8, 0), 16'h8001);
    step(1'b1, A(9, 0), 16'h9001, 1'b1, A(8, 0));
    chk(rd_valid && rd_data == 16'h8001, "R11 read side", rd_data, 16'h8001);
    rd_exp(A(9, 0), 1'b1, 16'h9001, "R11 write side");
  endtask

  task automatic t_halt;
    cfg(31, 4);
    for (int k = 0; k < 3; k++) wr(A(10, 0), 16'hA100 + 16'(k));
    chk(!halt, "R8 below", halt, 0);
    wr(A(10, 0), 16'hA103);
    chk(halt, "R8 at global thr", halt, 1);
    chk(bp[10] == 1'b0, "R7 queue thr independent", bp[10], 0);
    rd_exp(A(10, 0), 1'b1, 16'hA100, "R8 read");
    chk(!halt, "R8 release", halt, 0);
    for (int k = 1; k < 4; k++) rd_exp(A(10, 0), 1'b1, 16'hA100 + 16'(k), "R3 drain");
    cfg(31, 144);
  endtask

  task automatic t_overflow;
    cfg(31, 160);
    cfg(11, 200);
    cfg(12, 200);
    for (int k = 0; k < 80; k++) begin
      wr(A(11, 0), 16'hB000 + 16'(k));
      wr(A(12, 0), 16'hC000 + 16'(k));
    end
    chk(halt, "R8 pool full halt", halt, 1);
    chk(!overflow, "R9 no overflow at 160", overflow, 0);
    chk(bp[11] == 1'b0, "R7 oversubscribed thr", bp[11], 0);
    wr(A(13, 0), 16'hE001);
    chk(overflow, "R9 overflow set", overflow, 1);
    step(1'b1, A(13, 0), 16'hE002, 1'b1, A(11, 0));
    chk(rd_valid && rd_data == 16'hB000, "R9 read while full", rd_data, 16'hB000);
    rd_exp(A(13, 0), 1'b0, 16'h0, "R9 dropped writes");
    for (int k = 1; k < 80; k++) rd_exp(A(11, 0), 1'b1, 16'hB000 + 16'(k), "R9 drain q11");
    for (int k = 0; k < 80; k++) rd_exp(A(12, 0), 1'b1, 16'hC000 + 16'(k), "R9 drain q12");
    chk(overflow, "R9 sticky", overflow, 1);
    chk(!halt, "R8 empty", halt, 0);
    wr(A(13, 0), 16'hE003);
    rd_exp(A(13, 0), 1'b1, 16'hE003, "R11 slot reuse");
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_fifo;
    t_bad_queue;
    t_bp;
    t_same;
    t_rw_diff;
    t_halt;
    t_overflow;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule